// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

This block controls one bank of general-purpose pins, with up to 32 lines, through a simple 32-bit register bus. Each line is set up on its own as a plain input, a driven output or an interrupt source. An interrupt source can watch a level or an edge. Its polarity can be chosen. In edge mode it can also react to transitions in both directions.

Pin inputs first pass through a two-stage synchroniser. Edge events latch into a per-line status bit, and software clears that bit by writing ones. Level sources instead report their adjusted level directly. A mask register decides which status bits reach the single combined interrupt line. Software enables lines through a dedicated write-one-to-enable register and disables them by writing zeros to the mask register itself. Software reads the status, takes the lowest pending line first and clears its bit.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, no pin is driven and `irq_out` is low. The register offsets are: 0x00 mode (1 = interrupt, 0 = general I/O), 0x04 direction (1 = output), 0x08 output data, 0x0C input data, 0x10 status, 0x14 status clear, 0x18 mask, 0x1C mask enable, 0x20 polarity, 0x24 sense (1 = edge, 0 = level), 0x4C both-edge, 0x50 input enable. Reads of the status-clear and mask-enable offsets return 0.
- R2: `pin_oe[i]` is high exactly when mode bit i is 0 and direction bit i is 1. `pin_out[i]` carries output-data bit i.
- R3: Input data bit i equals the pin level after two synchroniser stages, ANDed with input-enable bit i. For an output pin this is the level being driven.
- R4: For a level-sensed interrupt line, the status bit equals the synchronised level XOR polarity bit (polarity 0 = active high), provided input enable is 1. Writing the clear register has no lasting effect on it.
- R5: For an edge-sensed line with both-edge at 0, a rising transition latches status when polarity is 0, and a falling transition latches it when polarity is 1. Status stays set until it is cleared.
- R6: For an edge-sensed line with both-edge at 1, either transition latches status, whatever the polarity.
- R7: Writing 1 to a status-clear bit clears that latched edge status, and 0 bits leave it unchanged. When a new edge arrives in the same cycle as the clear, the status ends up set.
- R8: Writing the mask-enable register ORs the written ones into the mask. Writing the mask register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R9: `irq_out` is high while any bit of (status AND mask) is 1.
- R10: Bits at or above NLINES read as 0 and ignore writes. Writes to the input-data and status offsets change nothing.
- R11: A line whose input-enable bit is 0 reads 0 in input data and produces no status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NLINES | Pad input levels |
| pin_out | output | NLINES | Pad output levels |
| pin_oe | output | NLINES | Pad output enables |
| irq_out | output | 1 | Combined interrupt request |

## Verification
An edge can reach a status bit in the same cycle that software writes the clear register for that bit. The latching path then competes with the clear path. The bench provokes this by counting edges from a pin change until the detector sees the transition, then landing the clear write exactly on the latching edge. It judges the outcome by reading the status and expecting the bit to stay set. Random sequences also change direction and mode while pins are looped back, so pin-level changes coincide with configuration changes, and a bench model predicts every status bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_MODE   = 8'h00;
  localparam logic [REG_AW-1:0] OFS_DIR    = 8'h04;
  localparam logic [REG_AW-1:0] OFS_ODATA  = 8'h08;
  localparam logic [REG_AW-1:0] OFS_IDATA  = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_STAT   = 8'h10;
  localparam logic [REG_AW-1:0] OFS_CLR    = 8'h14;
  localparam logic [REG_AW-1:0] OFS_MASK   = 8'h18;
  localparam logic [REG_AW-1:0] OFS_UNMASK = 8'h1C;
  localparam logic [REG_AW-1:0] OFS_POL    = 8'h20;
  localparam logic [REG_AW-1:0] OFS_SENSE  = 8'h24;
  localparam logic [REG_AW-1:0] OFS_BOTH   = 8'h4C;
  localparam logic [REG_AW-1:0] OFS_INEN   = 8'h50;

  typedef struct packed {
    logic [REG_DW-1:0] mode;
    logic [REG_DW-1:0] dir;
    logic [REG_DW-1:0] odata;
    logic [REG_DW-1:0] pol;
    logic [REG_DW-1:0] sense;
    logic [REG_DW-1:0] both;
    logic [REG_DW-1:0] inen;
  } bank_cfg_t;

  function automatic logic [REG_DW-1:0] line_mask(input int unsigned n);
    line_mask = (n >= REG_DW) ? '1 : ((REG_DW'(1) << n) - REG_DW'(1));
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);
  logic [WIDTH-1:0] stage1_q, stage2_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      hist_q   <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
      hist_q   <= stage2_q;
    end
  end

  assign q      = stage2_q;
  assign q_prev = hist_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output bank_cfg_t         cfg,
  output logic [REG_DW-1:0] mask,
  output logic [REG_DW-1:0] clr_pulse
);
  localparam logic [REG_DW-1:0] LMASK = line_mask(NLINES);

  bank_cfg_t         cfg_q, cfg_d;
  logic [REG_DW-1:0] mask_q, mask_d;
  logic [REG_DW-1:0] wd;

  assign wd = wdata & LMASK;

  always_comb begin
    cfg_d     = cfg_q;
    mask_d    = mask_q;
    clr_pulse = '0;
    if (wr_en) begin
      case (addr)
        OFS_MODE:   cfg_d.mode  = wd;
        OFS_DIR:    cfg_d.dir   = wd;
        OFS_ODATA:  cfg_d.odata = wd;
        OFS_POL:    cfg_d.pol   = wd;
        OFS_SENSE:  cfg_d.sense = wd;
        OFS_BOTH:   cfg_d.both  = wd;
        OFS_INEN:   cfg_d.inen  = wd;
        OFS_CLR:    clr_pulse   = wd;
        OFS_MASK:   mask_d      = mask_q & wd;
        OFS_UNMASK: mask_d      = mask_q | wd;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      cfg_q  <= cfg_d;
      mask_q <= mask_d;
    end
  end

  assign cfg  = cfg_q;
  assign mask = mask_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_cfg_t         cfg,
  input  logic [REG_DW-1:0] lvl,
  input  logic [REG_DW-1:0] lvl_prev,
  input  logic [REG_DW-1:0] clr,
  output logic [REG_DW-1:0] status
);
  localparam logic [REG_DW-1:0] LMASK = line_mask(NLINES);

  logic [REG_DW-1:0] latch_q, latch_d;
  logic [REG_DW-1:0] rise, fall, hit, armed, lvl_st;

  always_comb begin
    rise    = lvl & ~lvl_prev;
    fall    = ~lvl & lvl_prev;
    hit     = (cfg.both & (rise | fall))
            | (~cfg.both & ~cfg.pol & rise)
            | (~cfg.both &  cfg.pol & fall);
    armed   = cfg.mode & cfg.sense & cfg.inen;
    latch_d = ((latch_q & ~clr) | (hit & armed)) & LMASK;
    lvl_st  = cfg.mode & ~cfg.sense & cfg.inen & (lvl ^ cfg.pol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  assign status = ((latch_q & cfg.mode & cfg.sense) | lvl_st) & LMASK;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq_out
);
  localparam logic [REG_DW-1:0] LMASK = line_mask(NLINES);

  logic              rst_meta_q, rst_q;
  bank_cfg_t         cfg;
  logic [REG_DW-1:0] mask_w, clr_w, status_w, mode_w;
  logic [NLINES-1:0] sync_lvl, sync_prev;
  logic [REG_DW-1:0] lvl32, prev32, idata, oe32;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  gpio_pin_sync #(.WIDTH(NLINES)) u_sync (
    .clk(clk), .rst_n(rst_q), .d(pin_in), .q(sync_lvl), .q_prev(sync_prev)
  );

  assign lvl32  = REG_DW'(sync_lvl);
  assign prev32 = REG_DW'(sync_prev);

  gpio_bank_regs #(.NLINES(NLINES)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(bus_sel & bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cfg(cfg), .mask(mask_w), .clr_pulse(clr_w)
  );

  gpio_irq_detect #(.NLINES(NLINES)) u_det (
    .clk(clk), .rst_n(rst_q), .cfg(cfg), .lvl(lvl32), .lvl_prev(prev32),
    .clr(clr_w), .status(status_w)
  );

  assign mode_w  = cfg.mode;
  assign oe32    = ~cfg.mode & cfg.dir & LMASK;
  assign pin_oe  = oe32[NLINES-1:0];
  assign pin_out = cfg.odata[NLINES-1:0];
  assign idata   = lvl32 & cfg.inen;
  assign irq_out = |(status_w & mask_w);

  always_comb begin
    case (bus_addr)
      OFS_MODE:  bus_rdata = cfg.mode;
      OFS_DIR:   bus_rdata = cfg.dir;
      OFS_ODATA: bus_rdata = cfg.odata;
      OFS_IDATA: bus_rdata = idata;
      OFS_STAT:  bus_rdata = status_w;
      OFS_MASK:  bus_rdata = mask_w;
      OFS_POL:   bus_rdata = cfg.pol;
      OFS_SENSE: bus_rdata = cfg.sense;
      OFS_BOTH:  bus_rdata = cfg.both;
      OFS_INEN:  bus_rdata = cfg.inen;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int unsigned NLINES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [7:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       mode,
  input logic [31:0]       mask,
  input logic [31:0]       status,
  input logic [NLINES-1:0] pin_oe,
  input logic              irq_out
);
  localparam logic [31:0] LM = gpio_bank_pkg::line_mask(NLINES);

  p_unmask_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 8'h1C)
      |=> ((mask & $past(bus_wdata) & LM) == ($past(bus_wdata) & LM)));

  p_mask_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 8'h18)
      |=> ((mask & ~$past(bus_wdata)) == 32'd0));

  p_oe_general_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & mode[NLINES-1:0]) == '0));

  p_status_needs_irq_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~mode) == 32'd0));

  p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mask != 32'd0));

  p_upper_lines_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (((status | mask | mode) & ~LM) == 32'd0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_q), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mode(mode_w), .mask(mask_w),
  .status(status_w), .pin_oe(pin_oe), .irq_out(irq_out)
);

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  localparam int unsigned NL = 24;
  localparam logic [31:0] LM = (32'd1 << NL) - 32'd1;

  logic clk, rst_n, bus_sel, bus_wr, irq_out;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NL-1:0] pin_in, pin_out, pin_oe, ext;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [31:0] m_mode, m_dir, m_out, m_pol, m_sen, m_both, m_inen, m_mask, m_lat, m_pin;

  gpio_irq_bank #(.NLINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] eff_pin(input logic [31:0] e);
    logic [31:0] oe;
    oe = ~m_mode & m_dir;
    return ((oe & m_out) | (~oe & e)) & LM;
  endfunction

  function automatic logic [31:0] exp_status();
    return ((m_lat & m_mode & m_sen) | (m_mode & ~m_sen & m_inen & (m_pin ^ m_pol))) & LM;
  endfunction

  task automatic model_pins();
    logic [31:0] np, r, f, h;
    np = eff_pin(32'(ext));
    r = np & ~m_pin;
    f = ~np & m_pin;
    h = (m_both & (r | f)) | (~m_both & ~m_pol & r) | (~m_both & m_pol & f);
    m_lat = (m_lat | (h & m_mode & m_sen & m_inen)) & LM;
    m_pin = np;
  endtask

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] w;
    w = d & LM;
    case (a)
      8'h00: m_mode = w;
      8'h04: m_dir  = w;
      8'h08: m_out  = w;
      8'h14: m_lat  = m_lat & ~w;
      8'h18: m_mask = m_mask & w;
      8'h1C: m_mask = m_mask | w;
      8'h20: m_pol  = w;
      8'h24: m_sen  = w;
      8'h4C: m_both = w;
      8'h50: m_inen = w;
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    model_write(a, d);
    model_pins();
    settle();
  endtask

  task automatic drive(input logic [NL-1:0] v);
    @(negedge clk);
    ext = v;
    model_pins();
    settle();
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    rd(8'h0C, d); chk({tag, " R3 input data"}, d, m_pin & m_inen);
    rd(8'h10, d); chk({tag, " R4 status"}, d, exp_status());
    rd(8'h18, d); chk({tag, " R8 mask"}, d, m_mask);
    chk({tag, " R2 oe"}, 32'(pin_oe), ~m_mode & m_dir & LM);
    chk({tag, " R2 out"}, 32'(pin_out), m_out);
    chk({tag, " R9 irq"}, 32'(irq_out), 32'(|(exp_status() & m_mask)));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, seed;
    seed = $urandom(32'h5EED_0042);
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; ext = '0; rst_n = 0;
    {m_mode, m_dir, m_out, m_pol, m_sen, m_both, m_inen, m_mask, m_lat, m_pin} = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    settle();

    // R1 reset state, every offset reads zero
    foreach (d[i]) ;
    for (int a = 0; a <= 8'h50; a += 4) begin
      rd(8'(a), d);
      chk("R1 reset read", d, 32'd0);
    end
    chk("R1 reset oe", 32'(pin_oe), 32'd0);
    chk("R1 reset irq", 32'(irq_out), 32'd0);

    // R2 output drivers
    wr(8'h08, 32'h0000_00A5);
    wr(8'h04, 32'h0000_00FF);
    check_all("R2 outputs");
    wr(8'h00, 32'h0000_0001);
    chk("R2 interrupt mode drops oe", 32'(pin_oe), 32'h0000_00FE);
    wr(8'h00, 32'h0);

    // R3 / R11 input data with enable and loopback
    drive(24'h5A_3C00);
    rd(8'h0C, d); chk("R11 inen zero reads 0", d, 32'd0);
    wr(8'h50, 32'hFFFF_FFFF);
    check_all("R3 inputs");
    rd(8'h0C, d); chk("R3 output loopback", d & 32'hFF, 32'h0000_00A5);
    wr(8'h04, 32'h0);

    // R4 level sensing on line 10
    wr(8'h1C, 32'h0000_0400);
    wr(8'h00, 32'h0000_0400);
    drive(24'h00_0400);
    rd(8'h10, d); chk("R4 level high", d, 32'h0000_0400);
    chk("R9 irq on level", 32'(irq_out), 32'd1);
    wr(8'h14, 32'h0000_0400);
    rd(8'h10, d); chk("R4 clear no effect on level", d, 32'h0000_0400);
    wr(8'h20, 32'h0000_0400);
    rd(8'h10, d); chk("R4 polarity inverts", d, 32'd0);
    drive(24'h0);
    rd(8'h10, d); chk("R4 active low", d, 32'h0000_0400);
    wr(8'h00, 32'h0); wr(8'h20, 32'h0);

    // R5 single edge on line 5
    wr(8'h24, 32'h0000_0020);
    wr(8'h00, 32'h0000_0020);
    drive(24'h00_0020);
    rd(8'h10, d); chk("R5 rising latches", d, 32'h0000_0020);
    drive(24'h0);
    rd(8'h10, d); chk("R5 stays latched", d, 32'h0000_0020);
    wr(8'h14, 32'h0000_0000);
    rd(8'h10, d); chk("R7 zero clear ignored", d, 32'h0000_0020);
    wr(8'h14, 32'h0000_0020);
    rd(8'h10, d); chk("R7 clear", d, 32'd0);
    wr(8'h20, 32'h0000_0020);
    drive(24'h00_0020);
    rd(8'h10, d); chk("R5 falling pol ignores rise", d, 32'd0);
    drive(24'h0);
    rd(8'h10, d); chk("R5 falling latches", d, 32'h0000_0020);
    wr(8'h14, 32'h0000_0020);

    // R6 both edges
    wr(8'h4C, 32'h0000_0020);
    drive(24'h00_0020);
    rd(8'h10, d); chk("R6 rise with both", d, 32'h0000_0020);
    wr(8'h14, 32'h0000_0020);
    drive(24'h0);
    rd(8'h10, d); chk("R6 fall with both", d, 32'h0000_0020);
    wr(8'h14, 32'h0000_0020);
    wr(8'h4C, 32'h0); wr(8'h20, 32'h0);

    // R7 clear lands on the latching edge: set wins
    @(negedge clk); ext = 24'h00_0020;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h14; bus_wdata = 32'h0000_0020;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    model_write(8'h14, 32'h0000_0020);
    model_pins();
    settle();
    rd(8'h10, d); chk("R7 set wins over clear", d, 32'h0000_0020);

    // R8 mask paths
    wr(8'h1C, 32'h0000_00F0);
    wr(8'h18, 32'hFFFF_FF0F);
    rd(8'h18, d); chk("R8 zeros clear mask", d, 32'h0000_0400);
    chk("R9 masked line gives no irq", 32'(irq_out), 32'd0);
    wr(8'h1C, 32'h0000_0020);
    chk("R9 irq after unmask", 32'(irq_out), 32'd1);

    // R10 upper bits and read-only offsets
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, d); chk("R10 upper bits zero", d, LM);
    wr(8'h10, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    check_all("R10 read-only writes");
    rd(8'h14, d); chk("R1 clear reads 0", d, 32'd0);

    // R11 disabled input makes no status
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFDF);
    drive(24'h0);
    drive(24'h00_0020);
    rd(8'h10, d); chk("R11 no status when disabled", d & 32'h20, 32'd0);
    wr(8'h50, 32'hFFFF_FFFF);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [31:0] v;
      op = $urandom_range(0, 11);
      v = $urandom();
      case (op)
        0, 1, 2: drive(v[NL-1:0]);
        3: wr(8'h00, v);
        4: wr(8'h04, v);
        5: wr(8'h08, v);
        6: wr(8'h20, v);
        7: wr(8'h24, v);
        8: wr(8'h4C, v);
        9: wr(8'h14, v);
        10: wr(8'h18, v | $urandom());
        default: wr(8'h1C, v & $urandom());
      endcase
      if (it % 3 == 0) check_all("random");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule